// File: doc/BRIEF.md
# I2C Master Transaction Sequencer

This block runs whole I2C master write and master read transactions on top of a byte-level I2C engine. The engine handles bit timing on the wire. The sequencer tells it when to issue a start or a stop condition, which byte to shift out, and which acknowledge to return for each byte it receives. Each engine event (start done, byte done) comes back as a one-cycle completion pulse, and the sequencer answers every event it acts on with a one-cycle clear pulse. On the wire every byte takes nine SCL cycles: eight data bits and one acknowledge bit.

A transaction is described in a small local descriptor buffer that is written through a simple byte write port. Entry 0 holds the 7-bit slave address and entry 1 holds the byte count. For a write, the data bytes follow in order from entry 2. A start command then selects the direction. In a read, the received bytes are stored in a local receive buffer that can be read back through a read port once the data-ready output is high. A NACK from the slave aborts the transfer with a stop condition and raises a sticky error flag.

Top module: `i2c_txn_seq`

## Requirements
- R1: The first byte handed to the engine after the start condition is the slave address (descriptor entry 0, bits 6..0) shifted left by one. Bit 0 of that byte is 1 for a read and 0 for a write.
- R2: On the start-done event the start request drops, no stop request is made, and the address byte is presented on the transmit data output.
- R3: If the slave NACKs the address byte (`eng_ack_in` = 0), in either direction, the sequencer pulses the stop request, goes idle (busy low, data-ready low) and sets the error flag.
- R4: In a write, an ACKed address loads descriptor entry 2. Each further ACKed data byte loads the next entry. After the byte at entry 1 + count is ACKed, the sequencer pulses a stop and goes idle with the error flag clear.
- R5: In a write, a NACK on any data byte stops the transfer at once with a stop pulse, a return to idle and the error flag set. No further data byte is offered.
- R6: In a read, `eng_ack_out` (1 = ACK, 0 = NACK) is already set before each byte arrives. It is 1 for every byte except the last and 0 for the last, so a one-byte read NACKs its only byte.
- R7: Each received byte is stored at the receive-buffer index equal to the number of bytes received so far. When that number reaches the count, a stop is pulsed and `data_ready` goes high, busy goes low, and the bytes can be read back at indices 0 to count-1.
- R8: Every engine event that arrives while busy is answered with `eng_evt_clr` high for exactly the following cycle. An event that arrives while not busy causes no clear pulse and no change of state.
- R9: Busy is high from the cycle after an accepted start command until idle or data-ready is reached. A start command is accepted only while not busy, and one given while busy has no effect on the running transaction.
- R10: The error flag stays set after an abort or a rejection until the next accepted, valid start command clears it.
- R11: A descriptor whose count is zero, or larger than the buffer can serve (write: descriptor depth minus 2, read: receive depth), is rejected. Busy stays low, no start request is raised, and the error flag is set.
- R12: An accepted start command clears `data_ready` and raises the start request in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Descriptor buffer write strobe |
| cfg_addr | input | $clog2(DESC_DEPTH) | Descriptor buffer entry index |
| cfg_wdata | input | 8 | Descriptor byte to write |
| cmd_start | input | 1 | Start a transaction from the descriptor |
| cmd_read | input | 1 | Direction of the commanded transaction, 1 = read |
| busy | output | 1 | Transaction in progress |
| err | output | 1 | Sticky abort/reject flag |
| data_ready | output | 1 | Read finished, receive buffer valid |
| rx_raddr | input | $clog2(RX_DEPTH) | Receive buffer read index |
| rx_rdata | output | 8 | Receive buffer byte at rx_raddr |
| eng_sta | output | 1 | Start condition request to the engine |
| eng_sto | output | 1 | Stop condition request pulse to the engine |
| eng_txd | output | 8 | Byte for the engine to transmit |
| eng_ack_out | output | 1 | Acknowledge to return for the next received byte, 1 = ACK |
| eng_evt | input | 1 | One-cycle engine completion pulse |
| eng_ack_in | input | 1 | Slave acknowledge of the last sent byte, 1 = ACK |
| eng_rxd | input | 8 | Byte received by the engine |
| eng_evt_clr | output | 1 | One-cycle acknowledge of an engine event |

## Verification
A start command and an engine completion event can meet in the same cycle. The bench provokes this in two ways. First, it raises `cmd_start` together with the address-done event of a running write. The write must go on byte for byte, as the scoreboard expects, and must end with the error flag clear. Second, it raises `cmd_start` together with a stray event while idle. Here the command must be taken, shown by the start request rising the next cycle, while the event gets no clear pulse.

// File: rtl/i2c_seq_pkg.sv
// Shared types for the I2C master transaction sequencer.
// Assumes: the state encoding carries the direction, so one case
// statement serves both write and read sequences.
package i2c_seq_pkg;

    typedef enum logic [3:0] {
        S_IDLE   = 4'd0,
        S_W_STA  = 4'd1,
        S_W_ADDR = 4'd2,
        S_W_DATA = 4'd3,
        S_R_STA  = 4'd4,
        S_R_ADDR = 4'd5,
        S_R_DATA = 4'd6,
        S_DREADY = 4'd7
    } seq_state_e;

endpackage

// File: rtl/i2c_desc_buf.sv
// Descriptor buffer: DEPTH byte entries written through a byte port.
// Entry 0 and entry 1 (address, count) are always visible; one more
// read port serves the data byte the controller wants next.
// Assumes: writes happen while no transaction uses the buffer.
module i2c_desc_buf #(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] rd_idx,
    output logic [7:0]    hdr_addr,
    output logic [7:0]    hdr_cnt,
    output logic [7:0]    rd_data
);

    logic [7:0] ent [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        logic [7:0] q;
        // Hold one descriptor byte, loaded when its index is written.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= 8'h00;
            else if (we && waddr == AW'(g))
                q <= wdata;
        end
        assign ent[g] = q;
    end

    assign hdr_addr = ent[0];
    assign hdr_cnt  = ent[1];
    assign rd_data  = ent[rd_idx];

endmodule

// File: rtl/i2c_rx_store.sv
// Receive buffer: one byte per index, written by the controller as
// bytes arrive, read back asynchronously by the user.
// Assumes: the controller never writes at or beyond DEPTH.
module i2c_rx_store #(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);

    logic [7:0] ent [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        logic [7:0] q;
        // Hold one received byte, loaded when its index is written.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= 8'h00;
            else if (we && waddr == AW'(g))
                q <= wdata;
        end
        assign ent[g] = q;
    end

    assign rdata = ent[raddr];

endmodule

// File: rtl/i2c_seq_ctrl.sv
// Sequencer state machine. It walks one write or read transaction per
// accepted command, reacting to one engine event per step.
// Assumes: eng_evt is a single-cycle pulse; the engine samples eng_txd
// and eng_ack_out when it starts the next byte, after the clear pulse.
module i2c_seq_ctrl
    import i2c_seq_pkg::*;
#(
    parameter int DESC_DEPTH = 16,
    parameter int RX_DEPTH   = 16,
    localparam int DAW    = $clog2(DESC_DEPTH),
    localparam int RAW    = $clog2(RX_DEPTH),
    localparam int WR_MAX = DESC_DEPTH - 2,
    localparam int RD_MAX = RX_DEPTH
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cmd_start,
    input  logic           cmd_read,
    input  logic [7:0]     hdr_addr,
    input  logic [7:0]     hdr_cnt,
    input  logic [7:0]     dat_byte,
    output logic [DAW-1:0] dat_idx,
    input  logic           eng_evt,
    input  logic           eng_ack_in,
    input  logic [7:0]     eng_rxd,
    output logic           eng_sta,
    output logic           eng_sto,
    output logic [7:0]     eng_txd,
    output logic           eng_ack_out,
    output logic           eng_evt_clr,
    output logic           rx_we,
    output logic [RAW-1:0] rx_waddr,
    output logic [7:0]     rx_wdata,
    output logic           busy,
    output logic           err,
    output logic           data_ready
);

    seq_state_e state;
    logic [6:0] slv_addr;
    logic [7:0] cnt;
    logic [7:0] pos;
    logic       active;
    logic       accept;
    logic       bad_cnt;
    logic [7:0] pos_inc;

    // Decode whether a transaction is running and a command is taken.
    always_comb begin
        active  = (state != S_IDLE) && (state != S_DREADY);
        accept  = cmd_start && !active;
        pos_inc = pos + 8'd1;
        if (hdr_cnt == 8'd0)
            bad_cnt = 1'b1;
        else if (cmd_read)
            bad_cnt = int'(hdr_cnt) > RD_MAX;
        else
            bad_cnt = int'(hdr_cnt) > WR_MAX;
    end

    // Point the descriptor read port at the byte to load next.
    always_comb begin
        if (state == S_W_ADDR)
            dat_idx = DAW'(8'd2);
        else
            dat_idx = DAW'(pos + 8'd3);
    end

    // Store each received byte at the running count.
    always_comb begin
        rx_we    = eng_evt && (state == S_R_DATA);
        rx_waddr = RAW'(pos);
        rx_wdata = eng_rxd;
    end

    // Advance the transaction one step per engine event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= S_IDLE;
            slv_addr    <= 7'd0;
            cnt         <= 8'd0;
            pos         <= 8'd0;
            eng_sta     <= 1'b0;
            eng_sto     <= 1'b0;
            eng_txd     <= 8'h00;
            eng_ack_out <= 1'b0;
            eng_evt_clr <= 1'b0;
            err         <= 1'b0;
        end else begin
            eng_sto     <= 1'b0;
            eng_evt_clr <= 1'b0;
            if (accept) begin
                if (bad_cnt) begin
                    err   <= 1'b1;
                    state <= S_IDLE;
                end else begin
                    err      <= 1'b0;
                    cnt      <= hdr_cnt;
                    slv_addr <= hdr_addr[6:0];
                    pos      <= 8'd0;
                    eng_sta  <= 1'b1;
                    state    <= cmd_read ? S_R_STA : S_W_STA;
                end
            end else if (eng_evt && active) begin
                eng_evt_clr <= 1'b1;
                unique case (state)
                    S_W_STA, S_R_STA: begin
                        eng_sta <= 1'b0;
                        eng_txd <= {slv_addr, state == S_R_STA};
                        state   <= (state == S_R_STA) ? S_R_ADDR : S_W_ADDR;
                    end
                    S_W_ADDR: begin
                        if (!eng_ack_in) begin
                            eng_sto <= 1'b1;
                            err     <= 1'b1;
                            state   <= S_IDLE;
                        end else begin
                            eng_txd <= dat_byte;
                            pos     <= 8'd0;
                            state   <= S_W_DATA;
                        end
                    end
                    S_W_DATA: begin
                        if (!eng_ack_in) begin
                            eng_sto <= 1'b1;
                            err     <= 1'b1;
                            state   <= S_IDLE;
                        end else if (pos_inc == cnt) begin
                            eng_sto <= 1'b1;
                            state   <= S_IDLE;
                        end else begin
                            eng_txd <= dat_byte;
                            pos     <= pos_inc;
                        end
                    end
                    S_R_ADDR: begin
                        if (!eng_ack_in) begin
                            eng_sto <= 1'b1;
                            err     <= 1'b1;
                            state   <= S_IDLE;
                        end else begin
                            eng_ack_out <= (cnt != 8'd1);
                            pos         <= 8'd0;
                            state       <= S_R_DATA;
                        end
                    end
                    S_R_DATA: begin
                        pos <= pos_inc;
                        if (pos_inc == cnt) begin
                            eng_sto <= 1'b1;
                            state   <= S_DREADY;
                        end else begin
                            eng_ack_out <= (pos + 8'd2 != cnt);
                        end
                    end
                    default: state <= S_IDLE;
                endcase
            end
        end
    end

    assign busy       = active;
    assign data_ready = (state == S_DREADY);

    // R2: start and stop requests are never raised together.
    p_sta_sto_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(eng_sta && eng_sto));

    // R2: the start-done event drops the start request and enters an address state.
    p_sta_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_evt && (state == S_W_STA || state == S_R_STA)) |=>
        (!eng_sta && (state == S_W_ADDR || state == S_R_ADDR)));

    // R8: an event taken while running is cleared in the next cycle.
    p_clr_after_evt_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_evt && active) |=> eng_evt_clr);

    // R8: an event while not running is not acknowledged.
    p_no_clr_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_evt && !active && !accept) |=> (!eng_evt_clr && $stable(state)));

    // R3: a stop request always coincides with having left the running states.
    p_stop_ends_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        eng_sto |-> !active);

    // R7: received bytes land only inside the requested count.
    p_rx_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_we |-> (pos < cnt));

    // R9: a command while running leaves the running count untouched.
    p_cmd_busy_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start && active) |=> $stable(cnt));

endmodule

// File: rtl/i2c_txn_seq.sv
// Top of the I2C master transaction sequencer: the descriptor buffer,
// the receive buffer and the controlling state machine.
// Assumes: a byte-level engine on the eng_* pins that handles all bit
// timing and reports each finished step with a one-cycle pulse.
module i2c_txn_seq #(
    parameter int DESC_DEPTH = 16,
    parameter int RX_DEPTH   = 16,
    localparam int DAW = $clog2(DESC_DEPTH),
    localparam int RAW = $clog2(RX_DEPTH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_we,
    input  logic [DAW-1:0] cfg_addr,
    input  logic [7:0]     cfg_wdata,
    input  logic           cmd_start,
    input  logic           cmd_read,
    output logic           busy,
    output logic           err,
    output logic           data_ready,
    input  logic [RAW-1:0] rx_raddr,
    output logic [7:0]     rx_rdata,
    output logic           eng_sta,
    output logic           eng_sto,
    output logic [7:0]     eng_txd,
    output logic           eng_ack_out,
    input  logic           eng_evt,
    input  logic           eng_ack_in,
    input  logic [7:0]     eng_rxd,
    output logic           eng_evt_clr
);

    logic [7:0]     hdr_addr;
    logic [7:0]     hdr_cnt;
    logic [7:0]     dat_byte;
    logic [DAW-1:0] dat_idx;
    logic           rx_we;
    logic [RAW-1:0] rx_waddr;
    logic [7:0]     rx_wdata;

    i2c_desc_buf #(.DEPTH(DESC_DEPTH)) u_desc (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .waddr    (cfg_addr),
        .wdata    (cfg_wdata),
        .rd_idx   (dat_idx),
        .hdr_addr (hdr_addr),
        .hdr_cnt  (hdr_cnt),
        .rd_data  (dat_byte)
    );

    i2c_rx_store #(.DEPTH(RX_DEPTH)) u_rx (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (rx_we),
        .waddr (rx_waddr),
        .wdata (rx_wdata),
        .raddr (rx_raddr),
        .rdata (rx_rdata)
    );

    i2c_seq_ctrl #(.DESC_DEPTH(DESC_DEPTH), .RX_DEPTH(RX_DEPTH)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_start   (cmd_start),
        .cmd_read    (cmd_read),
        .hdr_addr    (hdr_addr),
        .hdr_cnt     (hdr_cnt),
        .dat_byte    (dat_byte),
        .dat_idx     (dat_idx),
        .eng_evt     (eng_evt),
        .eng_ack_in  (eng_ack_in),
        .eng_rxd     (eng_rxd),
        .eng_sta     (eng_sta),
        .eng_sto     (eng_sto),
        .eng_txd     (eng_txd),
        .eng_ack_out (eng_ack_out),
        .eng_evt_clr (eng_evt_clr),
        .rx_we       (rx_we),
        .rx_waddr    (rx_waddr),
        .rx_wdata    (rx_wdata),
        .busy        (busy),
        .err         (err),
        .data_ready  (data_ready)
    );

endmodule

// File: tb/test_i2c_txn_seq.sv
// Scoreboard bench: driver tasks push the expected engine-side items
// into a queue; the engine model pops and compares them as they appear.
module test_i2c_txn_seq;

    localparam int DD = 16;
    localparam int RD = 16;
    localparam int K_ADDR = 0;
    localparam int K_DATA = 1;
    localparam int K_ACK  = 2;
    localparam int K_STOP = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [3:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic       cmd_start = 1'b0;
    logic       cmd_read = 1'b0;
    logic       busy, err, data_ready;
    logic [3:0] rx_raddr = '0;
    logic [7:0] rx_rdata;
    logic       eng_sta, eng_sto, eng_ack_out, eng_evt_clr;
    logic [7:0] eng_txd;
    logic       eng_evt = 1'b0;
    logic       eng_ack_in = 1'b1;
    logic [7:0] eng_rxd = '0;

    typedef struct {
        int    kind;
        int    val;
        string req;
    } item_t;

    item_t exp_q[$];
    int    ack_q[$];
    int    rxb_q[$];
    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 1'b0;

    always #10 clk = ~clk;

    i2c_txn_seq #(.DESC_DEPTH(DD), .RX_DEPTH(RD)) i_i2c_txn_seq (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cmd_start(cmd_start), .cmd_read(cmd_read),
        .busy(busy), .err(err), .data_ready(data_ready),
        .rx_raddr(rx_raddr), .rx_rdata(rx_rdata),
        .eng_sta(eng_sta), .eng_sto(eng_sto), .eng_txd(eng_txd),
        .eng_ack_out(eng_ack_out), .eng_evt(eng_evt),
        .eng_ack_in(eng_ack_in), .eng_rxd(eng_rxd), .eng_evt_clr(eng_evt_clr)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic push(input int kind, input int val, input string req);
        item_t it;
        it.kind = kind; it.val = val; it.req = req;
        exp_q.push_back(it);
    endtask

    // Monitor side of the scoreboard: compare an observed item with the head.
    task automatic observe(input int kind, input int val);
        item_t it;
        n_chk++;
        if (exp_q.size() == 0) begin
            n_fail++;
            $display("FAIL unexpected item: actual kind %0d val %0d expected none", kind, val);
        end else begin
            it = exp_q.pop_front();
            if (it.kind != kind || it.val != val) begin
                n_fail++;
                $display("FAIL %s: actual kind %0d val 0x%0h expected kind %0d val 0x%0h",
                         it.req, kind, val, it.kind, it.val);
            end
        end
    endtask

    task automatic load_desc(input int a, input int n, input int d[8]);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            cfg_we    = 1'b1;
            cfg_addr  = 4'(i);
            cfg_wdata = (i == 0) ? 8'(a) : (i == 1) ? 8'(n) : 8'(d[i-2]);
        end
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // One engine event; R8: the clear pulse must follow it.
    task automatic pulse_evt(input bit poke, output bit stop);
        eng_evt = 1'b1;
        if (poke) begin cmd_start = 1'b1; cmd_read = 1'b1; end
        @(negedge clk);
        eng_evt = 1'b0;
        cmd_start = 1'b0;
        cmd_read = 1'b0;
        stop = eng_sto;
        chk(eng_evt_clr == 1'b1, "R8 clear pulse after event", int'(eng_evt_clr), 1);
        @(negedge clk);
    endtask

    // Engine model acting as the monitor of the transaction it serves.
    task automatic engine_run(input bit rd, input bit poke);
        int guard = 0;
        bit ended = 1'b0;
        bit s_seen;
        while (!eng_sta && guard < 20) begin @(negedge clk); guard++; end
        chk(eng_sta == 1'b1, "R12 start request raised", int'(eng_sta), 1);
        if (!eng_sta) return;
        repeat (2) @(negedge clk);
        pulse_evt(1'b0, s_seen);
        chk(eng_sta == 1'b0, "R2 start request dropped", int'(eng_sta), 0);
        chk(s_seen == 1'b0, "R2 no stop on start event", int'(s_seen), 0);
        observe(K_ADDR, int'(eng_txd));
        eng_ack_in = (ack_q.size() != 0) ? 1'(ack_q.pop_front()) : 1'b1;
        pulse_evt(poke, s_seen);
        guard = 0;
        while (!ended && guard < 40) begin
            guard++;
            if (s_seen) begin
                observe(K_STOP, 0);
                ended = 1'b1;
            end else if (rd) begin
                observe(K_ACK, int'(eng_ack_out));
                eng_rxd = (rxb_q.size() != 0) ? 8'(rxb_q.pop_front()) : 8'h00;
                pulse_evt(1'b0, s_seen);
            end else begin
                observe(K_DATA, int'(eng_txd));
                eng_ack_in = (ack_q.size() != 0) ? 1'(ack_q.pop_front()) : 1'b1;
                pulse_evt(1'b0, s_seen);
            end
        end
        eng_ack_in = 1'b1;
        chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
        exp_q.delete();
    endtask

    // Driver: a write of n bytes; nack_at = -1 none, 0 address, k+1 data byte k.
    task automatic run_write(input int a, input int n, input int d[8],
                             input int nack_at, input bit poke, input bit pre_started);
        int last;
        load_desc(a, n, d);
        push(K_ADDR, (a << 1) & 8'hfe, "R1 write address byte");
        ack_q.delete();
        for (int i = 0; i <= n; i++) ack_q.push_back((i == nack_at) ? 0 : 1);
        if (nack_at != 0) begin
            last = (nack_at > 0) ? nack_at - 1 : n - 1;
            for (int i = 0; i <= last; i++)
                push(K_DATA, d[i], (nack_at > 0) ? "R5 data before NACK" : "R4 data byte in order");
        end
        push(K_STOP, 0, (nack_at == 0) ? "R3 stop after address NACK" :
                        (nack_at > 0) ? "R5 stop after data NACK" : "R4 stop after last byte");
        if (!pre_started) begin
            @(negedge clk); cmd_start = 1'b1; cmd_read = 1'b0;
            @(negedge clk); cmd_start = 1'b0;
            chk(busy == 1'b1, "R9 busy after accepted start", int'(busy), 1);
            chk(data_ready == 1'b0, "R12 data-ready cleared", int'(data_ready), 0);
        end
        engine_run(1'b0, poke);
        chk(busy == 1'b0, "R4 idle after write", int'(busy), 0);
        chk(err == (nack_at >= 0), (nack_at >= 0) ? "R10 error after NACK" : "R10 error clear",
            int'(err), int'(nack_at >= 0));
    endtask

    // Driver: a read of n bytes with the given payload.
    task automatic run_read(input int a, input int n, input int d[8], input bit addr_nack);
        int z[8] = '{default: 0};
        load_desc(a, n, z);
        push(K_ADDR, ((a << 1) | 1) & 8'hff, "R1 read address byte");
        ack_q.delete(); rxb_q.delete();
        ack_q.push_back(addr_nack ? 0 : 1);
        if (!addr_nack)
            for (int i = 0; i < n; i++) begin
                push(K_ACK, (i == n - 1) ? 0 : 1, "R6 acknowledge chosen in advance");
                rxb_q.push_back(d[i]);
            end
        push(K_STOP, 0, addr_nack ? "R3 stop after read address NACK" : "R7 stop after count");
        @(negedge clk); cmd_start = 1'b1; cmd_read = 1'b1;
        @(negedge clk); cmd_start = 1'b0; cmd_read = 1'b0;
        chk(busy == 1'b1, "R9 busy after read start", int'(busy), 1);
        engine_run(1'b1, 1'b0);
        chk(busy == 1'b0, "R9 busy low after read", int'(busy), 0);
        chk(data_ready == !addr_nack, "R7 data-ready state", int'(data_ready), int'(!addr_nack));
        chk(err == addr_nack, "R3 error flag after read", int'(err), int'(addr_nack));
        if (!addr_nack)
            for (int i = 0; i < n; i++) begin
                rx_raddr = 4'(i);
                #1;
                chk(rx_rdata == 8'(d[i]), "R7 stored byte at its index", int'(rx_rdata), d[i]);
            end
    endtask

    // Driver: a rejected descriptor must cause no bus activity.
    task automatic run_reject(input int n, input bit rd);
        int z[8] = '{default: 0};
        bit seen = 1'b0;
        load_desc(7'h11, n, z);
        @(negedge clk); cmd_start = 1'b1; cmd_read = rd;
        @(negedge clk); cmd_start = 1'b0; cmd_read = 1'b0;
        for (int i = 0; i < 12; i++) begin
            if (eng_sta || busy) seen = 1'b1;
            @(negedge clk);
        end
        chk(!seen, "R11 no activity on rejected descriptor", int'(seen), 0);
        chk(err == 1'b1, "R11 error on rejected descriptor", int'(err), 1);
    endtask

    initial begin : watchdog
        int cyc = 0;
        while (!done && cyc < 100000) begin @(posedge clk); cyc++; end
        if (!done) begin
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail + 1);
            $finish;
        end
    end

    initial begin : main
        int d1[8] = '{8'hA5, 8'h3C, 8'h7E, 8'h01, 8'hFF, 8'h10, 8'h20, 8'h30};
        int d2[8] = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h77, 8'h88};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0, "R9 reset busy", int'(busy), 0);
        chk(err == 1'b0, "R10 reset error", int'(err), 0);
        chk(data_ready == 1'b0, "R7 reset data-ready", int'(data_ready), 0);
        chk(eng_sta == 1'b0 && eng_sto == 1'b0, "R2 reset requests", int'(eng_sta), 0);

        run_write(7'h2A, 3, d1, -1, 1'b0, 1'b0);          // R4 full write
        run_write(7'h55, 4, d2, 2, 1'b0, 1'b0);           // R5 NACK on data byte 1
        run_write(7'h13, 2, d1, 0, 1'b0, 1'b0);           // R3 address NACK on write
        run_write(7'h7F, 8, d2, -1, 1'b1, 1'b0);          // R9 command during running write
        run_read(7'h40, 1, d1, 1'b0);                     // R6 one-byte read
        run_read(7'h01, 5, d2, 1'b0);                     // R7 multi-byte read from data-ready
        run_read(7'h22, 3, d1, 1'b1);                     // R3 address NACK on read
        run_reject(0, 1'b0);                              // R11 zero count
        run_reject(15, 1'b0);                             // R11 write count too large
        run_reject(17, 1'b1);                             // R11 read count too large

        // R8: a stray event while idle is not acknowledged.
        @(negedge clk); eng_evt = 1'b1;
        @(negedge clk); eng_evt = 1'b0;
        chk(eng_evt_clr == 1'b0, "R8 idle event not cleared", int'(eng_evt_clr), 0);
        chk(busy == 1'b0 && eng_sta == 1'b0, "R8 idle event changes nothing", int'(busy), 0);

        // R9: command and stray event in the same idle cycle.
        load_desc(7'h3B, 1, d2);
        @(negedge clk); eng_evt = 1'b1; cmd_start = 1'b1; cmd_read = 1'b0;
        @(negedge clk); eng_evt = 1'b0; cmd_start = 1'b0;
        chk(eng_evt_clr == 1'b0, "R8 no clear for idle event with command", int'(eng_evt_clr), 0);
        chk(eng_sta == 1'b1, "R9 command taken alongside idle event", int'(eng_sta), 1);
        chk(err == 1'b0, "R10 error cleared by valid start", int'(err), 0);
        run_write(7'h3B, 1, d2, -1, 1'b0, 1'b1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule